// File: doc/BRIEF.md
# Staggered Readout Holdoff Timer

Every node on a shared fieldbus sends a burst of readout frames in answer to a broadcast synchronisation pulse that arrives about every 15 s. If all nodes answered at once, bus load would exceed its ceiling. The rule is that no more than four nodes may transmit at the same time, so that load stays at or below 60%. This block sits in each node and delays that node's burst by a programmable holdoff. Nodes are put in groups and each group gets its own holdoff: 0 for the first group, 10 ticks (1000 ms) for the second, 20 ticks for the third, and so on. A burst lasts about 800 ms, so each group finishes before the next one starts.

The holdoff is counted in strobes from a 100 ms tick. After the holdoff ends, the block raises a transmit permit. The permit stays high until the transmitter has reported a fixed number of completed frames. A second flag is high from the accepted sync pulse until the end of the burst. Holdoff values written while a cycle is running are kept and take effect at the next sync.

Top module: `readout_holdoff`

## Requirements
- R1: After reset, `tx_permit_o` and `burst_active_o` are both low.
- R2: A sync pulse taken while idle, with holdoff D > 0, raises `burst_active_o` on the next cycle. `tx_permit_o` rises on the cycle after the D-th tick strobe that follows the sync.
- R3: With holdoff 0, `tx_permit_o` and `burst_active_o` both rise on the cycle after the sync pulse.
- R4: A tick strobe that arrives in the same cycle as the accepted sync does not count toward the holdoff. Cycles without a tick leave the holdoff count unchanged.
- R5: The burst lasts for FRAMES frame-done pulses. On the cycle after the last one, `tx_permit_o` and `burst_active_o` both drop.
- R6: A frame-done pulse has no effect when no burst is running, either while idle or during the holdoff.
- R7: A sync pulse that arrives while `burst_active_o` is high is ignored. It neither restarts nor extends the holdoff or the burst.
- R8: A holdoff value written while idle is used by the next sync pulse. The unit is one tick.
- R9: A holdoff value written while the block is busy does not change the cycle in progress. It is applied at the next sync pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_i | input | 1 | Sync pulse, one cycle |
| tick_i | input | 1 | 100 ms tick strobe, one cycle |
| hold_wr_i | input | 1 | Write strobe for holdoff value |
| hold_val_i | input | HOLD_W | Holdoff in ticks |
| frame_done_i | input | 1 | Transmitter reports one frame completed |
| tx_permit_o | output | 1 | Node may transmit readout frames |
| burst_active_o | output | 1 | High from accepted sync until burst end |

## Verification
Sync can coincide with a tick strobe, and sync can also arrive while the block is still busy. The bench sweeps every holdoff from 0 to 7. On every other run it drives a tick in the sync cycle. During the holdoff and the burst it drives spurious sync and frame-done pulses. After each event it checks that the permit rises exactly one cycle after the D-th tick that follows the sync, and falls one cycle after the FRAMES-th frame completion. A separate sequence writes a new holdoff during a busy cycle. It then confirms that the current cycle keeps the old value and that the next sync uses the new one.

// File: rtl/readout_holdoff.sv
module readout_holdoff #(
  parameter int HOLD_W = 8,
  parameter int FRAMES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic              tick_i,
  input  logic              hold_wr_i,
  input  logic [HOLD_W-1:0] hold_val_i,
  input  logic              frame_done_i,
  output logic              tx_permit_o,
  output logic              burst_active_o
);
  localparam int FW = $clog2(FRAMES + 1);

  typedef enum logic [1:0] {S_IDLE, S_HOLD, S_BURST} st_t;

  st_t               st;
  logic [HOLD_W-1:0] hold_q, pend_q, left_q;
  logic              pend_v;
  logic [FW-1:0]     fleft_q;

  wire              idle = (st == S_IDLE);
  wire              go   = idle & sync_i;
  wire [HOLD_W-1:0] eff  = pend_v ? pend_q : hold_q;

  assign tx_permit_o    = (st == S_BURST);
  assign burst_active_o = !idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      pend_q <= '0;
      pend_v <= 1'b0;
    end else if (hold_wr_i && idle) begin
      hold_q <= hold_val_i;
      pend_v <= 1'b0;
    end else if (hold_wr_i) begin
      pend_q <= hold_val_i;
      pend_v <= 1'b1;
    end else if (go && pend_v) begin
      hold_q <= pend_q;
      pend_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      left_q  <= '0;
      fleft_q <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (sync_i) begin
            if (eff == '0) begin
              st      <= S_BURST;
              fleft_q <= FW'(FRAMES);
            end else begin
              st     <= S_HOLD;
              left_q <= eff;
            end
          end
        S_HOLD:
          if (tick_i) begin
            if (left_q == HOLD_W'(1)) begin
              st      <= S_BURST;
              fleft_q <= FW'(FRAMES);
            end else begin
              left_q <= left_q - 1'b1;
            end
          end
        S_BURST:
          if (frame_done_i) begin
            if (fleft_q == FW'(1)) st <= S_IDLE;
            else fleft_q <= fleft_q - 1'b1;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3
  zero_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && eff == '0) |=> tx_permit_o);

  // R2
  permit_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_permit_o) |-> $past(sync_i || tick_i));

  // R4
  hold_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && !tick_i) |=> (st == S_HOLD && $stable(left_q)));

  // R5
  burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_permit_o) |-> $past(frame_done_i));

  // R6
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !sync_i) |=> !burst_active_o);

  // R7
  sync_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BURST && sync_i && !frame_done_i) |=> (st == S_BURST && $stable(fleft_q)));

  // R9
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && hold_wr_i) |=> $stable(hold_q));

  // R5
  permit_in_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_permit_o |-> burst_active_o);
endmodule

// File: tb/readout_holdoff_tb.sv
module readout_holdoff_tb;
  localparam int HOLD_W = 8;
  localparam int FRAMES = 4;

  logic clk = 0, rst_n = 0;
  logic sync_i = 0, tick_i = 0, hold_wr_i = 0, frame_done_i = 0;
  logic [HOLD_W-1:0] hold_val_i = '0;
  logic tx_permit_o, burst_active_o;
  int checks = 0, errors = 0;
  bit done = 0;

  readout_holdoff #(.HOLD_W(HOLD_W), .FRAMES(FRAMES)) u_dut (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .tick_i(tick_i),
    .hold_wr_i(hold_wr_i), .hold_val_i(hold_val_i), .frame_done_i(frame_done_i),
    .tx_permit_o(tx_permit_o), .burst_active_o(burst_active_o));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [1:0] exp);
    checks++;
    if ({tx_permit_o, burst_active_o} !== exp) begin
      errors++;
      $display("FAIL %s: permit/active=%b expected %b at %0t", tag,
               {tx_permit_o, burst_active_o}, exp, $time);
    end
  endtask

  task automatic cyc(input bit s, input bit t, input bit f);
    sync_i = s; tick_i = t; frame_done_i = f;
    @(negedge clk);
    sync_i = 0; tick_i = 0; frame_done_i = 0;
  endtask

  task automatic wr(input int v);
    hold_wr_i = 1; hold_val_i = HOLD_W'(v);
    @(negedge clk);
    hold_wr_i = 0;
  endtask

  task automatic burst(input bit noise);
    for (int f = 1; f <= FRAMES; f++) begin
      cyc(noise, 0, 0);
      chk("R7 burst held", 2'b11);
      cyc(0, 0, 1);
      chk("R5 frame count", (f < FRAMES) ? 2'b11 : 2'b00);
    end
    cyc(0, 1, 1);
    chk("R6 done while idle", 2'b00);
  endtask

  task automatic run(input int d, input bit noise);
    cyc(1, noise, 0);
    chk(d == 0 ? "R3 zero holdoff" : "R2 armed", {d == 0, 1'b1});
    for (int t = 1; t <= d; t++) begin
      cyc(noise, 0, noise);
      chk("R4 R6 R7 no tick", 2'b01);
      cyc(0, 1, 0);
      chk("R2 tick count", {t == d, 1'b1});
    end
    burst(noise);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", 2'b00);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", 2'b00);
    for (int d = 0; d < 8; d++) begin
      wr(d);
      chk("R8 idle write", 2'b00);
      run(d, d % 2);
    end
    wr(3);
    cyc(1, 0, 0);
    chk("R9 armed", 2'b01);
    wr(0);
    chk("R9 busy write", 2'b01);
    for (int t = 1; t <= 3; t++) begin
      cyc(0, 1, 0);
      chk("R9 old holdoff kept", {t == 3, 1'b1});
    end
    burst(0);
    cyc(1, 0, 0);
    chk("R9 pending applied", 2'b11);
    burst(0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule